// File: doc/BRIEF.md
# Histogram-Ratio Pixel Weight Generator

This block produces the per-pixel weights used by one step of a mean-shift tracker. Software or an upstream block first writes two colour histograms into it, one for the tracked object's reference model and one for the current candidate window. A start pulse then begins a two-phase run.

In the first phase the block visits every bin in turn. For each bin it stores the square root of the model-to-candidate count ratio in a small ratio table, in unsigned 8.8 fixed point. A bin with an empty candidate count stores zero. The division and the square root are both done one bit per cycle.

Only after the whole table is written does the second phase begin. In that phase a valid/ready stream of pixel bin indices, one per pixel of a WIN_X by WIN_Y window, is turned into a stream of weights. Each weight is the table entry for that pixel's bin. The weights come out in input order, and the final one of the window carries a last flag.

Top module: `hist_weight_gen`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `busy`, `wt_valid` and `pix_ready` are low.
- R2: A bin whose candidate count is zero has a ratio of 0x0000, whatever its model count.
- R3: A bin with model count q and non-zero candidate count p has a ratio of floor(sqrt(floor(q·65536/p))). This is the 8.8 value of sqrt(q/p) rounded down; for example q=400, p=100 gives 0x0200, and q=9, p=16 gives 0x00C0.
- R4: `pix_ready` stays low from the start pulse until the ratio entries of all NUM_BINS bins have been written. Pixels offered in that time are not taken.
- R5: Exactly one weight is emitted per accepted pixel, in acceptance order. It equals the ratio of the bin index given with that pixel.
- R6: `wt_last` is high on the WIN_X·WIN_Y-th weight of a run and low on all others.
- R7: `busy` rises in the cycle after an accepted start pulse. It stays high until the edge at which the last weight is taken (`wt_valid`, `wt_ready` and `wt_last` all high), and is low in the following cycle. A start pulse while `busy` is high has no effect.
- R8: With the output register free, a pixel accepted at clock edge k makes its weight valid right after edge k+1. While `wt_valid` is high and `wt_ready` is low, `wt_data` and `wt_last` hold their values.
- R9: A histogram write (`hist_we`, with `hist_sel` 0 for the model and 1 for the candidate, bin in `hist_addr`) made while `busy` is high is dropped. A write made while idle is used by the next run.
- R10: After WIN_X·WIN_Y pixels have been accepted in a run, `pix_ready` stays low for the rest of that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hist_we | input | 1 | Histogram bin write strobe |
| hist_sel | input | 1 | 0 writes the model histogram, 1 the candidate histogram |
| hist_addr | input | $clog2(NUM_BINS) | Bin being written |
| hist_data | input | CNT_W | Bin count |
| start | input | 1 | Begin a run (taken only when idle) |
| pix_valid | input | 1 | Pixel bin index is offered |
| pix_ready | output | 1 | Pixel bin index is taken at this edge when valid |
| pix_bin | input | $clog2(NUM_BINS) | Histogram bin of the pixel |
| wt_valid | output | 1 | Weight output is valid |
| wt_ready | input | 1 | Downstream takes the weight |
| wt_data | output | (CNT_W+2·FRAC_W)/2 | Pixel weight, unsigned 8.8 fixed point by default |
| wt_last | output | 1 | Marks the final weight of the window |
| busy | output | 1 | A run is in progress |

## Verification
A pixel taken at edge k has its weight valid after edge k+1. The bench samples every handshake in the middle of the low clock phase, counts cycles from the first acceptance, and requires the first weight exactly two samples later. The ratio phase takes a data-dependent number of cycles. Instead of predicting that length, the bench keeps a pixel offered from the start pulse and requires `pix_ready` low over the first 50 cycles, a span shorter than even the quickest ratio of the first bin. `busy` is sampled in the cycle after the last weight is taken, and weights under back-pressure are compared with the value seen in the stalled cycle before.

// File: rtl/hwg_pkg.sv
package hwg_pkg;

  // run phases of the weight generator
  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_RD     = 3'd1,
    PH_LOAD   = 3'd2,
    PH_DIV    = 3'd3,
    PH_SQRT   = 3'd4,
    PH_WR     = 3'd5,
    PH_STREAM = 3'd6
  } phase_t;

  // histogram selector values on hist_sel
  localparam logic SEL_MODEL = 1'b0;
  localparam logic SEL_CAND  = 1'b1;

endpackage

// File: rtl/hwg_sdp_ram.sv
module hwg_sdp_ram #(
  parameter int DEPTH = 16,
  parameter int DW    = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // registered read with enable, holds value when re is low
  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/hwg_seq_div.sv
module hwg_seq_div #(
  parameter int NUM_W = 32,
  parameter int DEN_W = 16,
  localparam int CW   = $clog2(NUM_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             done,
  output logic [NUM_W-1:0] quot
);

  logic [DEN_W-1:0] rem_q;
  logic [DEN_W-1:0] den_q;
  logic [CW-1:0]    cnt_q;
  logic             run_q;
  logic [DEN_W:0]   trial;
  logic [DEN_W-1:0] diff;
  logic             ge;

  // restoring step: bring down next numerator bit
  always_comb begin
    trial = {rem_q, quot[NUM_W-1]};
    ge    = (trial >= {1'b0, den_q});
    diff  = trial[DEN_W-1:0] - den_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      done  <= 1'b0;
      cnt_q <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        rem_q <= '0;
        quot  <= num;
        den_q <= den;
        cnt_q <= '0;
        run_q <= 1'b1;
      end else if (run_q) begin
        rem_q <= ge ? diff : trial[DEN_W-1:0];
        quot  <= {quot[NUM_W-2:0], ge};
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CW'(NUM_W-1)) begin
          run_q <= 1'b0;
          done  <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/hwg_seq_isqrt.sv
module hwg_seq_isqrt #(
  parameter int IN_W  = 32,
  localparam int OUT_W = IN_W / 2,
  localparam int CW    = $clog2(OUT_W + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [IN_W-1:0]  rad,
  output logic             done,
  output logic [OUT_W-1:0] root
);

  logic [IN_W-1:0]  op_q;
  logic [OUT_W+1:0] rem_q;
  logic [CW-1:0]    cnt_q;
  logic             run_q;
  logic [OUT_W+3:0] nxt;
  logic [OUT_W+3:0] trial;
  logic [OUT_W+1:0] diff;
  logic             ge;

  // digit-by-digit: two radicand bits per step, one root bit out
  always_comb begin
    nxt   = {rem_q, op_q[IN_W-1:IN_W-2]};
    trial = {2'b00, root, 2'b01};
    ge    = (nxt >= trial);
    diff  = nxt[OUT_W+1:0] - trial[OUT_W+1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      done  <= 1'b0;
      cnt_q <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        op_q  <= rad;
        rem_q <= '0;
        root  <= '0;
        cnt_q <= '0;
        run_q <= 1'b1;
      end else if (run_q) begin
        op_q  <= {op_q[IN_W-3:0], 2'b00};
        rem_q <= ge ? diff : nxt[OUT_W+1:0];
        root  <= {root[OUT_W-2:0], ge};
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CW'(OUT_W-1)) begin
          run_q <= 1'b0;
          done  <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/hist_weight_gen.sv
module hist_weight_gen
  import hwg_pkg::*;
#(
  parameter int NUM_BINS = 16,
  parameter int CNT_W    = 16,
  parameter int FRAC_W   = 8,
  parameter int WIN_X    = 8,
  parameter int WIN_Y    = 4,
  localparam int BIN_W   = $clog2(NUM_BINS),
  localparam int DIVN_W  = CNT_W + 2 * FRAC_W,
  localparam int WGT_W   = DIVN_W / 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hist_we,
  input  logic             hist_sel,
  input  logic [BIN_W-1:0] hist_addr,
  input  logic [CNT_W-1:0] hist_data,
  input  logic             start,
  input  logic             pix_valid,
  output logic             pix_ready,
  input  logic [BIN_W-1:0] pix_bin,
  output logic             wt_valid,
  input  logic             wt_ready,
  output logic [WGT_W-1:0] wt_data,
  output logic             wt_last,
  output logic             busy
);

  localparam int PIX_N  = WIN_X * WIN_Y;
  localparam int PIX_CW = $clog2(PIX_N + 1);
  localparam logic [BIN_W-1:0] LAST_BIN = BIN_W'(NUM_BINS - 1);

  phase_t state;
  logic [BIN_W-1:0]  bin_idx;
  logic [WGT_W-1:0]  ratio_r;
  logic [PIX_CW-1:0] in_cnt;
  logic [CNT_W-1:0]  model_q, cand_q;
  logic              model_we, cand_we, hist_re;
  logic              div_start, div_done, sq_start, sq_done;
  logic [DIVN_W-1:0] quot;
  logic [WGT_W-1:0]  sq_root;
  logic              ratio_we;
  logic [WGT_W-1:0]  ratio_rd;
  logic              pix_acc, out_free, s1_adv;
  logic              s1_valid, s1_last;

  assign busy = (state != PH_IDLE);

  // histogram storage, writable only while idle
  assign model_we = hist_we && !busy && (hist_sel == SEL_MODEL);
  assign cand_we  = hist_we && !busy && (hist_sel == SEL_CAND);
  assign hist_re  = (state == PH_RD);

  hwg_sdp_ram #(.DEPTH(NUM_BINS), .DW(CNT_W)) model_ram_i (
    .clk(clk), .we(model_we), .waddr(hist_addr), .wdata(hist_data),
    .re(hist_re), .raddr(bin_idx), .rdata(model_q)
  );

  hwg_sdp_ram #(.DEPTH(NUM_BINS), .DW(CNT_W)) cand_ram_i (
    .clk(clk), .we(cand_we), .waddr(hist_addr), .wdata(hist_data),
    .re(hist_re), .raddr(bin_idx), .rdata(cand_q)
  );

  // per-bin arithmetic: (q << 2F) / p then integer square root
  assign div_start = (state == PH_LOAD) && (cand_q != '0);
  assign sq_start  = (state == PH_DIV) && div_done;

  hwg_seq_div #(.NUM_W(DIVN_W), .DEN_W(CNT_W)) div_i (
    .clk(clk), .rst(rst), .start(div_start),
    .num({model_q, {(2*FRAC_W){1'b0}}}), .den(cand_q),
    .done(div_done), .quot(quot)
  );

  hwg_seq_isqrt #(.IN_W(DIVN_W)) sqrt_i (
    .clk(clk), .rst(rst), .start(sq_start), .rad(quot),
    .done(sq_done), .root(sq_root)
  );

  // phase sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= PH_IDLE;
      bin_idx <= '0;
      ratio_r <= '0;
      in_cnt  <= '0;
    end else begin
      case (state)
        PH_IDLE: begin
          if (start) begin
            bin_idx <= '0;
            state   <= PH_RD;
          end
        end
        PH_RD:   state <= PH_LOAD;
        PH_LOAD: begin
          if (cand_q == '0) begin
            ratio_r <= '0;
            state   <= PH_WR;
          end else begin
            state <= PH_DIV;
          end
        end
        PH_DIV:  if (div_done) state <= PH_SQRT;
        PH_SQRT: begin
          if (sq_done) begin
            ratio_r <= sq_root;
            state   <= PH_WR;
          end
        end
        PH_WR: begin
          if (bin_idx == LAST_BIN) begin
            in_cnt <= '0;
            state  <= PH_STREAM;
          end else begin
            bin_idx <= bin_idx + 1'b1;
            state   <= PH_RD;
          end
        end
        PH_STREAM: begin
          if (pix_acc) in_cnt <= in_cnt + 1'b1;
          if (wt_valid && wt_ready && wt_last) state <= PH_IDLE;
        end
        default: state <= PH_IDLE;
      endcase
    end
  end

  // ratio table: written in phase one, looked up per pixel in phase two
  assign ratio_we = (state == PH_WR);

  hwg_sdp_ram #(.DEPTH(NUM_BINS), .DW(WGT_W)) ratio_ram_i (
    .clk(clk), .we(ratio_we), .waddr(bin_idx), .wdata(ratio_r),
    .re(pix_acc), .raddr(pix_bin), .rdata(ratio_rd)
  );

  // two-stage lookup pipeline: table read stage, output register
  assign out_free  = !wt_valid || wt_ready;
  assign s1_adv    = out_free || !s1_valid;
  assign pix_ready = (state == PH_STREAM) && (in_cnt != PIX_CW'(PIX_N)) && s1_adv;
  assign pix_acc   = pix_valid && pix_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_last  <= 1'b0;
    end else begin
      if (s1_adv) s1_valid <= pix_acc;
      if (pix_acc) s1_last <= (in_cnt == PIX_CW'(PIX_N - 1));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wt_valid <= 1'b0;
      wt_last  <= 1'b0;
      wt_data  <= '0;
    end else if (out_free) begin
      wt_valid <= s1_valid;
      wt_last  <= s1_valid && s1_last;
      wt_data  <= ratio_rd;
    end
  end

endmodule

// File: rtl/hwg_checker.sv
module hwg_checker #(
  parameter int NUM_BINS = 16,
  parameter int PIX_N    = 32,
  parameter int WGT_W    = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             busy,
  input logic             pix_ready,
  input logic             wt_valid,
  input logic             wt_ready,
  input logic             wt_last,
  input logic [WGT_W-1:0] wt_data,
  input logic             ratio_we
);

  logic [15:0] wr_cnt;
  logic [15:0] out_cnt;

  always_ff @(posedge clk) begin
    if (rst || (start && !busy)) begin
      wr_cnt  <= '0;
      out_cnt <= '0;
    end else begin
      if (ratio_we) wr_cnt <= wr_cnt + 1'b1;
      if (wt_valid && wt_ready) out_cnt <= out_cnt + 1'b1;
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> (!busy && !wt_valid && !pix_ready));

  // R4
  table_first_chk: assert property (@(posedge clk) disable iff (rst)
    pix_ready |-> (wr_cnt == 16'(NUM_BINS)));

  // R6
  last_slot_chk: assert property (@(posedge clk) disable iff (rst)
    (wt_valid && wt_last) |-> (out_cnt == 16'(PIX_N - 1)));

  // R7
  busy_end_chk: assert property (@(posedge clk) disable iff (rst)
    (wt_valid && wt_ready && wt_last) |=> !busy);

  // R7
  busy_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> !busy);

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wt_valid && !wt_ready) |=> (wt_valid && $stable(wt_data) && $stable(wt_last)));

  // R10
  window_cap_chk: assert property (@(posedge clk) disable iff (rst)
    (wt_valid && wt_ready && !wt_last) |-> (out_cnt < 16'(PIX_N - 1)));

endmodule

bind hist_weight_gen hwg_checker #(
  .NUM_BINS(NUM_BINS),
  .PIX_N(WIN_X * WIN_Y),
  .WGT_W((CNT_W + 2 * FRAC_W) / 2)
) chk_i (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .pix_ready(pix_ready),
  .wt_valid(wt_valid), .wt_ready(wt_ready), .wt_last(wt_last),
  .wt_data(wt_data), .ratio_we(ratio_we)
);

// File: tb/hist_weight_gen_tb.sv
module hist_weight_gen_tb_top;

  localparam int CLK_P  = 10;
  localparam int NB     = 16;
  localparam int PIX_N  = 32;

  // {model count, candidate count, expected 8.8 ratio}
  localparam logic [47:0] VEC [0:15] = '{
    {16'd100,   16'd100,   16'h0100},
    {16'd400,   16'd100,   16'h0200},
    {16'd25,    16'd100,   16'h0080},
    {16'd0,     16'd50,    16'h0000},
    {16'd77,    16'd0,     16'h0000},
    {16'd0,     16'd0,     16'h0000},
    {16'd65535, 16'd1,     16'hFFFF},
    {16'd1,     16'd65535, 16'h0001},
    {16'd900,   16'd100,   16'h0300},
    {16'd1,     16'd4,     16'h0080},
    {16'd9,     16'd16,    16'h00C0},
    {16'd2,     16'd1,     16'h016A},
    {16'd1,     16'd1,     16'h0100},
    {16'd64,    16'd1,     16'h0800},
    {16'd3,     16'd12,    16'h0080},
    {16'd1000,  16'd10,    16'h0A00}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hist_we = 1'b0;
  logic        hist_sel = 1'b0;
  logic [3:0]  hist_addr = '0;
  logic [15:0] hist_data = '0;
  logic        start = 1'b0;
  logic        pix_valid = 1'b0;
  logic        pix_ready;
  logic [3:0]  pix_bin = '0;
  logic        wt_valid;
  logic        wt_ready = 1'b0;
  logic [15:0] wt_data;
  logic        wt_last;
  logic        busy;

  int n_tests = 0;
  int n_fail  = 0;
  logic [15:0] exp_w [NB];
  logic [15:0] cand_cnt [NB];

  always #(CLK_P/2) clk = ~clk;

  hist_weight_gen dut_i (
    .clk(clk), .rst(rst), .hist_we(hist_we), .hist_sel(hist_sel),
    .hist_addr(hist_addr), .hist_data(hist_data), .start(start),
    .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_bin(pix_bin),
    .wt_valid(wt_valid), .wt_ready(wt_ready), .wt_data(wt_data),
    .wt_last(wt_last), .busy(busy)
  );

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] bin_of(input int win, input int idx);
    return 4'((idx * 7 + win * 5 + 3) % NB);
  endfunction

  task automatic hist_write(input logic sel, input int addr, input int data);
    @(negedge clk);
    hist_we = 1'b1; hist_sel = sel; hist_addr = 4'(addr); hist_data = 16'(data);
    @(negedge clk);
    hist_we = 1'b0;
  endtask

  // one run: mode 1 adds back-pressure and a write while busy
  task automatic run_window(input int win, input bit bp, input bit busy_wr);
    int in_i = 0, out_i = 0, cyc = 0, first_acc = -1, first_val = -1;
    logic prev_stall = 1'b0;
    logic [15:0] prev_data = '0;
    logic prev_last = 1'b0;
    bit early_ok = 1'b1, cap_ok = 1'b1, busy_ok = 1'b1, cap_seen = 1'b0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    #1;
    check(busy == 1'b1, "R7 busy after start", busy, 1);
    while (out_i < PIX_N) begin
      @(negedge clk);
      pix_valid = (in_i < PIX_N);
      pix_bin   = bin_of(win, in_i);
      wt_ready  = bp ? ((cyc % 3) != 1) : 1'b1;
      hist_we   = busy_wr && (cyc == 60);
      hist_sel  = 1'b0; hist_addr = 4'd1; hist_data = 16'd0;
      #1;
      if (cyc < 50 && pix_ready) early_ok = 1'b0;
      if (in_i == PIX_N) begin
        cap_seen = 1'b1;
        if (pix_ready) cap_ok = 1'b0;
      end
      if (!busy) busy_ok = 1'b0;
      if (prev_stall)
        check(wt_valid && wt_data == prev_data && wt_last == prev_last,
              "R8 stalled weight held", wt_data, prev_data);
      if (wt_valid && first_val < 0) first_val = cyc;
      if (wt_valid && wt_ready) begin
        logic [3:0] b = bin_of(win, out_i);
        if (cand_cnt[b] == 0)
          check(wt_data == exp_w[b], "R2 zero candidate", wt_data, exp_w[b]);
        else if (b == 4'd1 && win >= 2)
          check(wt_data == exp_w[b], "R9 bin1 weight", wt_data, exp_w[b]);
        else
          check(wt_data == exp_w[b], "R3 R5 weight", wt_data, exp_w[b]);
        check(wt_last == (out_i == PIX_N - 1), "R6 last flag", wt_last, out_i == PIX_N - 1);
        out_i++;
      end
      if (pix_valid && pix_ready) begin
        if (first_acc < 0) first_acc = cyc;
        in_i++;
      end
      prev_stall = wt_valid && !wt_ready;
      prev_data  = wt_data;
      prev_last  = wt_last;
      cyc++;
    end
    @(negedge clk);
    pix_valid = 1'b0; hist_we = 1'b0;
    #1;
    check(early_ok, "R4 ready low in ratio phase", early_ok, 1);
    check(busy_ok, "R7 busy held", busy_ok, 1);
    check(busy == 1'b0, "R7 busy low after last", busy, 0);
    check(cap_ok && cap_seen, "R10 ready low after window", cap_ok, 1);
    if (!bp) check(first_val - first_acc == 2, "R8 latency", first_val - first_acc, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(!busy && !wt_valid && !pix_ready, "R1 reset outputs", {busy, wt_valid, pix_ready}, 0);
    rst = 1'b0;
    #1;
    check(!busy && !wt_valid && !pix_ready, "R1 after release", {busy, wt_valid, pix_ready}, 0);

    // vector table walk: load histograms and expected ratios
    for (int i = 0; i < NB; i++) begin
      hist_write(1'b0, i, int'(VEC[i][47:32]));
      hist_write(1'b1, i, int'(VEC[i][31:16]));
      exp_w[i]    = VEC[i][15:0];
      cand_cnt[i] = VEC[i][31:16];
    end

    run_window(0, 1'b0, 1'b0);
    run_window(1, 1'b1, 1'b1);   // model bin1 write while busy must be dropped
    run_window(2, 1'b0, 1'b0);   // R9: bin1 still 0x0200

    hist_write(1'b0, 1, 100);    // idle write: bin1 becomes 1.0
    exp_w[1] = 16'h0100;
    run_window(3, 1'b1, 1'b0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule